// File: doc/BRIEF.md
# Simultaneous-Sample ADC Conversion Sequencer

This block is the digital control sequencer for a four-channel front end. Four sample-and-hold stages share one successive-approximation converter. When a convert request is accepted, all four channel inputs are captured in the same clock edge. The selected channels are then digitized one after another through a single converter. The converter here is a behavioural stub that returns the held sample, left justified, after a fixed latency. Each finished channel lands in a result register of its own. The end of a group raises a status flag, and an interrupt output is driven from that flag when software has enabled it.

The sequencer enforces a minimum acquisition interval, so that the hold capacitors recharge after reset and after every group. A convert request that arrives too early is not refused. It is remembered and carried out once the interval has elapsed. A mode bit in the control register chooses between a two-channel group (V then W) and a four-channel group (U, V, W, AUX). Software can read the results in any order while the block is idle.

Top module: `ssq_conv_seq`

## Requirements
- R1: After synchronous reset, `busy`, `irq`, `stat_q`, `ctrl_q` and all four result outputs are zero. The control state is two-channel mode with the interrupt disabled.
- R2: A group never starts until ACQ_CYC (20) clock cycles have passed since the reset edge or since the edge that ended the previous group. A start that is seen while idle but too early is kept pending. `busy` then rises exactly at the 20th edge after the reset or group-end edge.
- R3: All four inputs are captured at the edge that accepts a start. Input changes after that edge do not alter that group's results.
- R4: With control bit 3 clear, a group converts V and then W. V is written 40 edges after acceptance and W is written 80 edges after acceptance. `res_u` and `res_aux` keep their values.
- R5: With control bit 3 set, a group converts U, V, W and AUX in that order. Their results are written at 40, 80, 120 and 160 edges after acceptance.
- R6: Each result is the 11-bit two's complement sample in bits 11:1, with bit 0 forced to zero.
- R7: `busy` rises at the accepting edge and falls at the edge that writes the last result of the group. A start seen while `busy` is high is dropped and causes no later group.
- R8: `stat_q` bit 0 is the end-of-group flag, set at the edge where `busy` falls. `stat_q` bit 1 mirrors `busy`, and the other status bits are zero. A `stat_rd` pulse clears the flag. If a group ends on the same edge as a read, the flag stays set.
- R9: `irq` is high exactly when the end-of-group flag is set and control bit 7 is set.
- R10: `ctrl_q` returns only control bits 3 and 7 as written, with every other bit reading zero. The mode is sampled at the accepting edge, so a write made during a group takes effect from the next group.
- R11: Result outputs change only at the edge where their own channel finishes. They hold steady for as long as the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert request, sampled at each rising edge |
| ain_u | input | 11 | Channel U sample, two's complement |
| ain_v | input | 11 | Channel V sample, two's complement |
| ain_w | input | 11 | Channel W sample, two's complement |
| ain_aux | input | 11 | Channel AUX sample, two's complement |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data (bit 3 four-channel mode, bit 7 interrupt enable) |
| ctrl_q | output | 8 | Control register readback |
| stat_rd | input | 1 | Status read strobe; clears the end-of-group flag |
| stat_q | output | 8 | Status (bit 0 end-of-group flag, bit 1 busy) |
| res_u | output | 12 | Channel U result, left justified |
| res_v | output | 12 | Channel V result, left justified |
| res_w | output | 12 | Channel W result, left justified |
| res_aux | output | 12 | Channel AUX result, left justified |
| busy | output | 1 | Group in progress |
| irq | output | 1 | End-of-group interrupt |

## Verification
A slip in the acquisition counter or a stale pending-start bit shows up on the first group after reset. It also shows up on any start held through a group end, as `busy` rising one edge early or late, or rising again with no new request. A wrong slot counter or hold capture puts a result on the wrong port, or at the wrong multiple of 40 edges. It can also put a post-capture input value into a result, and any of these is visible within one conversion period. A flag-priority error shows only in the single cycle where a status read meets a group end, so the bench aligns those two events on purpose.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    localparam int unsigned ACQ_CYC_DEF  = 20;
    localparam int unsigned CONV_CYC_DEF = 40;
    localparam int unsigned SMP_W_DEF    = 11;
    localparam int unsigned NCH          = 4;
    localparam int unsigned CTRL_W       = 8;

    localparam int unsigned CTRL_QUAD_POS = 3;
    localparam int unsigned CTRL_IE_POS   = 7;
    localparam int unsigned STAT_DONE_POS = 0;
    localparam int unsigned STAT_BUSY_POS = 1;

    typedef enum logic [1:0] {
        CH_U   = 2'd0,
        CH_V   = 2'd1,
        CH_W   = 2'd2,
        CH_AUX = 2'd3
    } ch_e;

    typedef struct packed {
        logic ie;
        logic quad;
    } ctrl_t;

    function automatic ch_e first_chan(input logic quad);
        return quad ? CH_U : CH_V;
    endfunction

    function automatic logic [1:0] last_slot(input logic quad);
        return quad ? 2'd3 : 2'd1;
    endfunction

    function automatic ch_e slot_to_chan(input logic quad, input logic [1:0] slot);
        return ch_e'(quad ? slot : slot + 2'd1);
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_image(input ctrl_t c);
        logic [CTRL_W-1:0] img;
        img = '0;
        img[CTRL_QUAD_POS] = c.quad;
        img[CTRL_IE_POS]   = c.ie;
        return img;
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.quad = w[CTRL_QUAD_POS];
        c.ie   = w[CTRL_IE_POS];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[CTRL_QUAD_POS] = 1'b1;
        m[CTRL_IE_POS]   = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ssq_acq_timer.sv
module ssq_acq_timer
    import ssq_pkg::*;
#(
    parameter int unsigned ACQ_CYC = ACQ_CYC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic ready
);
    localparam int unsigned AW = (ACQ_CYC > 2) ? $clog2(ACQ_CYC) : 1;
    localparam logic [AW-1:0] LAST = AW'(ACQ_CYC - 1);

    logic [AW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = (cnt_q == LAST);

    // once the interval has elapsed it stays elapsed until the next group ends
    p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (ready && !restart) |=> ready);

endmodule

// File: rtl/ssq_conv_stub.sv
module ssq_conv_stub
    import ssq_pkg::*;
#(
    parameter int unsigned CONV_CYC = CONV_CYC_DEF,
    parameter int unsigned SMP_W    = SMP_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [SMP_W-1:0] din,
    output logic             done,
    output logic [SMP_W:0]   dout
);
    localparam int unsigned CW = (CONV_CYC > 2) ? $clog2(CONV_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CONV_CYC - 1);

    logic             run_q;
    logic [CW-1:0]    cnt_q;
    logic [SMP_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            data_q <= '0;
        end else if (go) begin
            run_q  <= 1'b1;
            cnt_q  <= '0;
            data_q <= din;
        end else if (done) begin
            run_q  <= 1'b0;
        end else if (run_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign done = run_q && (cnt_q == LAST);
    assign dout = {data_q, 1'b0};

    // a fresh conversion never completes on the very next cycle
    p_no_early_done_r5: assert property (@(posedge clk) disable iff (rst)
        go |=> !done);

endmodule

// File: rtl/ssq_seq_fsm.sv
module ssq_seq_fsm
    import ssq_pkg::*;
#(
    parameter int unsigned SMP_W = SMP_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       conv_start,
    input  logic                       acq_ready,
    input  logic                       quad_cfg,
    input  logic [NCH-1:0][SMP_W-1:0]  ain_vec,
    input  logic                       cv_done,
    output logic                       go,
    output logic [SMP_W-1:0]           go_data,
    output logic                       busy,
    output logic                       wr_en,
    output ch_e                        cur_ch,
    output logic                       grp_end
);
    logic                      busy_q;
    logic                      pend_q;
    logic                      quad_q;
    logic [1:0]                slot_q;
    logic [NCH-1:0][SMP_W-1:0] hold_q;

    logic accept;
    logic is_last;
    ch_e  next_ch;

    always_comb begin
        accept  = !busy_q && acq_ready && (conv_start || pend_q);
        is_last = (slot_q == last_slot(quad_q));
        cur_ch  = slot_to_chan(quad_q, slot_q);
        next_ch = slot_to_chan(quad_q, slot_q + 2'd1);
        wr_en   = busy_q && cv_done;
        grp_end = wr_en && is_last;
        go      = accept || (wr_en && !is_last);
        go_data = accept ? ain_vec[first_chan(quad_cfg)] : hold_q[next_ch];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            quad_q <= 1'b0;
            slot_q <= '0;
            hold_q <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            pend_q <= 1'b0;
            quad_q <= quad_cfg;
            slot_q <= '0;
            hold_q <= ain_vec;
        end else begin
            if (!busy_q && conv_start) begin
                pend_q <= 1'b1;
            end
            if (wr_en) begin
                if (is_last) begin
                    busy_q <= 1'b0;
                end else begin
                    slot_q <= slot_q + 2'd1;
                end
            end
        end
    end

    assign busy = busy_q;

    // a group runs until its last channel finishes (R7)
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !grp_end) |=> busy_q);

    // held samples do not move during a group (R3)
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !grp_end) |=> $stable(hold_q));

    // no start is remembered across a busy period (R7)
    p_no_pend_busy_r7: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> !pend_q);

endmodule

// File: rtl/ssq_conv_seq.sv
module ssq_conv_seq
    import ssq_pkg::*;
#(
    parameter int unsigned ACQ_CYC  = ACQ_CYC_DEF,
    parameter int unsigned CONV_CYC = CONV_CYC_DEF,
    parameter int unsigned SMP_W    = SMP_W_DEF,
    localparam int unsigned RES_W   = SMP_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic [SMP_W-1:0]  ain_u,
    input  logic [SMP_W-1:0]  ain_v,
    input  logic [SMP_W-1:0]  ain_w,
    input  logic [SMP_W-1:0]  ain_aux,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              stat_rd,
    output logic [CTRL_W-1:0] stat_q,
    output logic [RES_W-1:0]  res_u,
    output logic [RES_W-1:0]  res_v,
    output logic [RES_W-1:0]  res_w,
    output logic [RES_W-1:0]  res_aux,
    output logic              busy,
    output logic              irq
);
    localparam int unsigned GW = $clog2(ACQ_CYC + 1);

    ctrl_t                      ctrl_r;
    logic                       eoc_q;
    logic [NCH-1:0][SMP_W-1:0]  ain_vec;
    logic [NCH-1:0][RES_W-1:0]  res_q;

    logic             acq_ready;
    logic             go;
    logic [SMP_W-1:0] go_data;
    logic             cv_done;
    logic [SMP_W:0]   cv_dout;
    logic             wr_en;
    ch_e              cur_ch;
    logic             grp_end;
    logic             unused_wbits;

    assign ain_vec      = {ain_aux, ain_w, ain_v, ain_u};
    assign unused_wbits = ^(ctrl_wdata & ~ctrl_mask());

    ssq_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq (
        .clk     (clk),
        .rst     (rst),
        .restart (grp_end),
        .ready   (acq_ready)
    );

    ssq_seq_fsm #(.SMP_W(SMP_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .conv_start (conv_start),
        .acq_ready  (acq_ready),
        .quad_cfg   (ctrl_r.quad),
        .ain_vec    (ain_vec),
        .cv_done    (cv_done),
        .go         (go),
        .go_data    (go_data),
        .busy       (busy),
        .wr_en      (wr_en),
        .cur_ch     (cur_ch),
        .grp_end    (grp_end)
    );

    ssq_conv_stub #(.CONV_CYC(CONV_CYC), .SMP_W(SMP_W)) u_cv (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .din  (go_data),
        .done (cv_done),
        .dout (cv_dout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= '0;
        end else if (ctrl_we) begin
            ctrl_r <= ctrl_decode(ctrl_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eoc_q <= 1'b0;
        end else if (grp_end) begin
            eoc_q <= 1'b1;
        end else if (stat_rd) begin
            eoc_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_res
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[g] <= '0;
            end else if (wr_en && (int'(cur_ch) == g)) begin
                res_q[g] <= cv_dout;
            end
        end
    end

    always_comb begin
        stat_q                = '0;
        stat_q[STAT_DONE_POS] = eoc_q;
        stat_q[STAT_BUSY_POS] = busy;
        ctrl_q                = ctrl_image(ctrl_r);
        irq                   = eoc_q && ctrl_r.ie;
    end

    assign res_u   = res_q[CH_U];
    assign res_v   = res_q[CH_V];
    assign res_w   = res_q[CH_W];
    assign res_aux = res_q[CH_AUX];

    // idle-run counter used only by the gap property below
    logic [GW-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst || busy) begin
            gap_q <= '0;
        end else if (gap_q != GW'(ACQ_CYC)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_acq_gap_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (gap_q >= GW'(ACQ_CYC)));

    p_flag_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_q) |-> $fell(busy));

    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !grp_end) |=> !eoc_q);

    p_res_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(res_q));

    p_write_busy_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_q) |-> $past(busy));

endmodule

// File: tb/ssq_conv_seq_bench.sv
module ssq_conv_seq_bench;
    import ssq_pkg::*;

    localparam int CLK_P = 10;
    localparam int NV    = 6;
    // {quad, u, v, w, aux}
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 11'h3FF, 11'h400, 11'h000, 11'h7FF},
        {1'b0, 11'h155, 11'h2AA, 11'h001, 11'h123},
        {1'b1, 11'h0F0, 11'h70F, 11'h5A5, 11'h25A},
        {1'b0, 11'h7FF, 11'h3FF, 11'h400, 11'h000},
        {1'b1, 11'h001, 11'h002, 11'h004, 11'h008},
        {1'b0, 11'h600, 11'h0AB, 11'h7FE, 11'h333}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic [10:0] ain_u = '0, ain_v = '0, ain_w = '0, ain_aux = '0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_q;
    logic        stat_rd = 1'b0;
    logic [7:0]  stat_q;
    logic [11:0] res_u, res_v, res_w, res_aux;
    logic        busy, irq;

    int n_run  = 0;
    int n_fail = 0;
    bit ie_exp = 1'b0;
    logic [11:0] e_res [4] = '{default: '0};

    always #(CLK_P/2) clk = ~clk;

    ssq_conv_seq u_ssq_conv_seq (
        .clk(clk), .rst(rst), .conv_start(conv_start),
        .ain_u(ain_u), .ain_v(ain_v), .ain_w(ain_w), .ain_aux(ain_aux),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .stat_rd(stat_rd), .stat_q(stat_q),
        .res_u(res_u), .res_v(res_v), .res_w(res_w), .res_aux(res_aux),
        .busy(busy), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        ctrl_we = 1'b1; ctrl_wdata = d;
        step(1);
        ctrl_we = 1'b0;
    endtask

    task automatic read_stat();
        stat_rd = 1'b1;
        step(1);
        stat_rd = 1'b0;
    endtask

    task automatic chk_results(input string tag);
        chk({tag, " res_u"},   {20'b0, res_u},   {20'b0, e_res[0]});
        chk({tag, " res_v"},   {20'b0, res_v},   {20'b0, e_res[1]});
        chk({tag, " res_w"},   {20'b0, res_w},   {20'b0, e_res[2]});
        chk({tag, " res_aux"}, {20'b0, res_aux}, {20'b0, e_res[3]});
    endtask

    // caller guarantees the acquisition interval has elapsed
    task automatic run_group(input logic quad, input logic [10:0] u, input logic [10:0] v,
                             input logic [10:0] w, input logic [10:0] x);
        int n;
        n = quad ? 4 : 2;
        ain_u = u; ain_v = v; ain_w = w; ain_aux = x;
        conv_start = 1'b1;
        step(1);
        conv_start = 1'b0;
        chk("R7 busy at accept", {31'b0, busy}, 32'd1);
        ain_u = ~u; ain_v = ~v; ain_w = ~w; ain_aux = ~x;   // R3: post-capture change
        if (quad) e_res[0] = {u, 1'b0};
        e_res[1] = {v, 1'b0};
        e_res[2] = {w, 1'b0};
        if (quad) e_res[3] = {x, 1'b0};
        step(40 * n - 1);
        chk("R7 busy before last", {31'b0, busy}, 32'd1);
        step(1);
        chk("R7 busy after last", {31'b0, busy}, 32'd0);
        chk("R8 flag set", {31'b0, stat_q[0]}, 32'd1);
        chk("R9 irq", {31'b0, irq}, {31'b0, ie_exp});
        chk_results(quad ? "R5 R6 R3" : "R4 R6 R3");
        read_stat();
        chk("R8 read clears", {24'b0, stat_q}, 32'd0);
        chk("R9 irq cleared", {31'b0, irq}, 32'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 stat", {24'b0, stat_q}, 32'd0);
        chk("R1 ctrl", {24'b0, ctrl_q}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk_results("R1");

        // R2: early start right after reset, pulsed once, stretched until acquired
        ain_u = 11'h111; ain_v = 11'h2C3; ain_w = 11'h4D5; ain_aux = 11'h066;
        rst = 1'b0;
        conv_start = 1'b1;
        step(1);
        conv_start = 1'b0;
        step(18);
        chk("R2 not before interval", {31'b0, busy}, 32'd0);
        step(1);
        chk("R2 stretched start", {31'b0, busy}, 32'd1);
        ain_v = 11'h000; ain_w = 11'h000;               // R3
        e_res[1] = {11'h2C3, 1'b0};
        e_res[2] = {11'h4D5, 1'b0};
        step(39);
        chk("R4 V not yet", {20'b0, res_v}, 32'd0);
        chk("R8 busy bit", {31'b0, stat_q[1]}, 32'd1);
        step(1);
        chk("R4 V at 40", {20'b0, res_v}, {20'b0, e_res[1]});
        chk("R4 W not yet", {20'b0, res_w}, 32'd0);
        step(9);
        conv_start = 1'b1;                              // R7: start while busy
        step(1);
        conv_start = 1'b0;
        step(29);
        chk("R7 busy held", {31'b0, busy}, 32'd1);
        step(1);
        chk("R4 busy end", {31'b0, busy}, 32'd0);
        chk_results("R4 R3 two-channel");
        chk("R8 stat after group", {24'b0, stat_q}, 32'd1);
        chk("R9 irq disabled", {31'b0, irq}, 32'd0);
        step(25);
        chk("R7 dropped start", {31'b0, busy}, 32'd0);
        chk_results("R11 idle hold");
        read_stat();
        chk("R8 read clears", {24'b0, stat_q}, 32'd0);

        write_ctrl(8'hFF);
        chk("R10 ctrl mask", {24'b0, ctrl_q}, 32'h88);

        for (int i = 0; i < NV; i++) begin
            write_ctrl(VEC[i][44] ? 8'h88 : 8'h80);
            ie_exp = 1'b1;
            step(25);
            run_group(VEC[i][44], VEC[i][43:33], VEC[i][32:22], VEC[i][21:11], VEC[i][10:0]);
        end

        // R10: mode change during a two-channel group applies next time
        write_ctrl(8'h80);
        step(25);
        ain_v = 11'h0C0; ain_w = 11'h0D0; ain_u = 11'h0E0; ain_aux = 11'h0F0;
        conv_start = 1'b1;
        step(1);
        conv_start = 1'b0;
        write_ctrl(8'h88);
        e_res[1] = {11'h0C0, 1'b0};
        e_res[2] = {11'h0D0, 1'b0};
        step(78);
        chk("R10 busy still", {31'b0, busy}, 32'd1);
        step(1);
        chk("R10 two-channel length", {31'b0, busy}, 32'd0);
        chk_results("R10 R4 old mode");
        chk("R10 ctrl readback", {24'b0, ctrl_q}, 32'h88);
        read_stat();

        // R8: read on the same edge as the group end keeps the flag
        step(25);
        ain_u = 11'h101; ain_v = 11'h202; ain_w = 11'h303; ain_aux = 11'h404;
        conv_start = 1'b1;
        step(1);
        conv_start = 1'b0;
        e_res[0] = {11'h101, 1'b0}; e_res[1] = {11'h202, 1'b0};
        e_res[2] = {11'h303, 1'b0}; e_res[3] = {11'h404, 1'b0};
        step(158);
        stat_rd = 1'b1;
        step(1);
        chk("R8 flag clear pre-end", {31'b0, stat_q[0]}, 32'd0);
        step(1);
        stat_rd = 1'b0;
        chk("R8 set wins", {31'b0, stat_q[0]}, 32'd1);
        chk("R9 irq set", {31'b0, irq}, 32'd1);
        chk_results("R5 four-channel");

        // R2: start held high through the group end is accepted after the interval
        conv_start = 1'b1;
        step(19);
        chk("R2 back-to-back wait", {31'b0, busy}, 32'd0);
        step(1);
        chk("R2 back-to-back go", {31'b0, busy}, 32'd1);
        conv_start = 1'b0;
        step(160);
        chk("R5 group length", {31'b0, busy}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule